// File: doc/BRIEF.md
# Two-Client Mutual-Exclusion Arbiter

This block gives one shared resource to one of two clients at a time. Each client raises a request, keeps it high while it uses the resource, and then drops it. The arbiter answers with at most one grant. A grant, once given, stays high until its own request falls. A request from the other client that arrives meanwhile does not disturb the grant. That request waits and is served as soon as the holder lets go.

When both requests are first seen high on the same clock edge, the arbiter makes a choice rather than treating the two as concurrent. The tie-break is fixed at elaboration. In one mode client A always wins. In the other mode the client that did not receive the most recent grant wins. Grants are registered outputs, so each decision becomes visible one clock after the edge that samples the requests.

Top module: `arb2_mutex`

## Requirements
- R1: While rst_n is low at a clock edge, both grants are low after that edge, whatever the requests are.
- R2: From idle (no grant), if only req_a is high at an edge, gnt_a is high and gnt_b is low after that edge.
- R3: From idle, if only req_b is high at an edge, gnt_b is high and gnt_a is low after that edge.
- R4: gnt_a and gnt_b are never high together.
- R5: While a client holds the grant and its request stays high, the grant stays high, whatever the other request does.
- R6: When the holder's request is sampled low, its grant is low after that same edge.
- R7: A request that waited through another client's grant is granted one edge after the holder's grant falls, provided it is still high.
- R8: With TIE_MODE set to TIE_FIXED_A, if both requests are high at an edge from idle, gnt_a is given.
- R9: With TIE_MODE set to TIE_ROTATE, if both requests are high at an edge from idle, the client that did not receive the most recent grant wins. After reset, A counts as the winner.
- R10: A grant is never raised for a client whose request is low at the deciding edge. Idle with both requests low stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_a | input | 1 | Request from client A |
| req_b | input | 1 | Request from client B |
| gnt_a | output | 1 | Grant to client A, registered |
| gnt_b | output | 1 | Grant to client B, registered |

## Verification
The bench holds A's grant while B's request rises, falls and rises again. A design that re-arbitrated at each edge would hand the resource to B while A still owned it, or would drop A's grant. It then releases A with B still waiting, and checks both the empty cycle between the two grants and B's grant after it. A design that skipped the gap would briefly overlap the grants. A design that forgot the waiting request would leave B unserved. Simultaneous first arrivals are driven into a fixed-priority instance and a rotating instance side by side, after a history that makes the two modes disagree, so a rotation pointer that never advances is exposed.

// File: rtl/arb2_pkg.sv
// Package: shared types for the two-client mutual-exclusion arbiter.
// Assumes: exactly two clients; state encoding is internal to the block.
package arb2_pkg;

    // Ownership state of the shared resource.
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_OWN_A = 2'd1,
        ARB_OWN_B = 2'd2
    } arb_state_t;

    // Tie-break rule applied when both requests are first seen together.
    typedef enum logic {
        TIE_FIXED_A = 1'b0,
        TIE_ROTATE  = 1'b1
    } tie_mode_t;

endpackage

// File: rtl/arb2_pick.sv
// Module: arb2_pick
// Combinational choice of the next owner when the resource is idle.
// Assumes: it is only consulted from idle; last_b says B received the most
// recent grant (used only by the rotating rule).
module arb2_pick
    import arb2_pkg::*;
#(
    parameter tie_mode_t TIE_MODE = TIE_FIXED_A
) (
    input  logic req_a,
    input  logic req_b,
    input  logic last_b,
    output logic pick_b
);

    generate
        if (TIE_MODE == TIE_FIXED_A) begin : g_fixed
            // A fixed preference for A: B wins only when alone.
            logic unused_last;
            assign unused_last = last_b;
            assign pick_b      = req_b & ~req_a;
        end else begin : g_rotate
            // Rotating preference: on a tie, B wins if A was served last.
            assign pick_b = req_b & (~req_a | ~last_b);
        end
    endgenerate

endmodule

// File: rtl/arb2_fsm.sv
// Module: arb2_fsm
// Owner state register and rotation pointer of the arbiter.
// Assumes: requests are already synchronous to clk; reset is synchronous and
// active low. A released grant always passes through idle for one cycle.
module arb2_fsm
    import arb2_pkg::*;
#(
    parameter tie_mode_t TIE_MODE = TIE_FIXED_A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_a,
    input  logic       req_b,
    output arb_state_t state
);

    arb_state_t state_nx;
    logic       last_b;
    logic       pick_b;

    arb2_pick #(.TIE_MODE(TIE_MODE)) u_pick (
        .req_a (req_a),
        .req_b (req_b),
        .last_b(last_b),
        .pick_b(pick_b)
    );

    // Next-state decision: grant from idle, hold while owned, release on drop.
    always_comb begin
        state_nx = state;
        case (state)
            ARB_IDLE:  if (req_a || req_b) state_nx = pick_b ? ARB_OWN_B : ARB_OWN_A;
            ARB_OWN_A: if (!req_a)         state_nx = ARB_IDLE;
            ARB_OWN_B: if (!req_b)         state_nx = ARB_IDLE;
            default:                       state_nx = ARB_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ARB_IDLE;
        else        state <= state_nx;
    end

    // Remember which client was granted most recently (B at reset, so A leads).
    always_ff @(posedge clk) begin
        if (!rst_n)                                          last_b <= 1'b1;
        else if (state == ARB_IDLE && (req_a || req_b))      last_b <= pick_b;
    end

    // R5
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_OWN_A && req_a) |=> (state == ARB_OWN_A));
    // R5
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_OWN_B && req_b) |=> (state == ARB_OWN_B));
    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ARB_OWN_A && !req_a) || (state == ARB_OWN_B && !req_b)) |=> (state == ARB_IDLE));
    // R10
    no_idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && !req_a && !req_b) |=> (state == ARB_IDLE));

    generate
        if (TIE_MODE == TIE_FIXED_A) begin : g_fixed_chk
            // R8
            tie_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (state == ARB_IDLE && req_a && req_b) |=> (state == ARB_OWN_A));
        end
    endgenerate

endmodule

// File: rtl/arb2_mutex.sv
// Module: arb2_mutex (top)
// Two-client mutual-exclusion arbiter with registered grants.
// Assumes: clients hold a request until served and drop it to release;
// tie-break rule is chosen at elaboration through TIE_MODE.
module arb2_mutex
    import arb2_pkg::*;
#(
    parameter tie_mode_t TIE_MODE = TIE_FIXED_A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic req_b,
    output logic gnt_a,
    output logic gnt_b
);

    arb_state_t state;

    arb2_fsm #(.TIE_MODE(TIE_MODE)) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .req_a(req_a),
        .req_b(req_b),
        .state(state)
    );

    // Grants decode directly from the registered owner state.
    always_comb begin
        gnt_a = (state == ARB_OWN_A);
        gnt_b = (state == ARB_OWN_B);
    end

    // R4
    mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_a && gnt_b));
    // R3
    lone_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_a && !gnt_b && req_b && !req_a) |=> gnt_b);
    // R2
    lone_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_a && !gnt_b && req_a && !req_b) |=> gnt_a);

endmodule

// File: tb/arb2_mutex_bench.sv
module arb2_mutex_bench;
    import arb2_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_a = 1'b0;
    logic req_b = 1'b0;
    logic gnt_a, gnt_b, rr_gnt_a, rr_gnt_b;
    int   n_chk = 0;
    int   n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    arb2_mutex #(.TIE_MODE(TIE_FIXED_A)) u_arb2_mutex (
        .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
        .gnt_a(gnt_a), .gnt_b(gnt_b));

    arb2_mutex #(.TIE_MODE(TIE_ROTATE)) u_arb2_mutex_rr (
        .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
        .gnt_a(rr_gnt_a), .gnt_b(rr_gnt_b));

    // Advance one edge and settle one time unit after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: grants {a,b} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_both(input string tag, input logic [1:0] exp_fix, input logic [1:0] exp_rr);
        chk({tag, " fixed"}, {gnt_a, gnt_b}, exp_fix);
        chk({tag, " rotate"}, {rr_gnt_a, rr_gnt_b}, exp_rr);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_a = 1'b1; req_b = 1'b1;
        repeat (3) tick();
        chk_both("R1 reset with requests high", 2'b00, 2'b00);
        req_a = 1'b0; req_b = 1'b0; rst_n = 1'b1;
        tick();
        chk_both("R1 after reset", 2'b00, 2'b00);
    endtask

    task automatic t_idle();
        repeat (3) tick();
        chk_both("R10 idle stays idle", 2'b00, 2'b00);
    endtask

    task automatic t_lone_a();
        req_a = 1'b1; tick();
        chk_both("R2 lone A granted", 2'b10, 2'b10);
        req_a = 1'b0; tick();
        chk_both("R6 A release", 2'b00, 2'b00);
        tick();
        chk_both("R10 no grant after release", 2'b00, 2'b00);
    endtask

    task automatic t_lone_b();
        req_b = 1'b1; tick();
        chk_both("R3 lone B granted", 2'b01, 2'b01);
        req_b = 1'b0; tick();
        chk_both("R6 B release", 2'b00, 2'b00);
    endtask

    task automatic t_hold_and_queue();
        req_a = 1'b1; tick();
        chk_both("R2 A granted", 2'b10, 2'b10);
        req_b = 1'b1;
        repeat (3) tick();
        chk_both("R5 R4 A held while B waits", 2'b10, 2'b10);
        req_b = 1'b0; tick();
        chk_both("R5 A held when B drops", 2'b10, 2'b10);
        req_b = 1'b1; tick();
        chk_both("R5 A held when B returns", 2'b10, 2'b10);
        req_a = 1'b0; tick();
        chk_both("R6 A falls with B waiting", 2'b00, 2'b00);
        tick();
        chk_both("R7 waiting B served", 2'b01, 2'b01);
        req_a = 1'b1;
        repeat (2) tick();
        chk_both("R5 B held while A waits", 2'b01, 2'b01);
        req_b = 1'b0; tick();
        chk_both("R6 B falls with A waiting", 2'b00, 2'b00);
        tick();
        chk_both("R7 waiting A served", 2'b10, 2'b10);
        req_a = 1'b0; tick(); tick();
        chk_both("R10 back to idle", 2'b00, 2'b00);
    endtask

    task automatic t_ties();
        do_reset();
        req_a = 1'b1; req_b = 1'b1; tick();
        chk_both("R8 R9 first tie after reset", 2'b10, 2'b10);
        req_a = 1'b0; req_b = 1'b0; tick();
        req_a = 1'b1; req_b = 1'b1; tick();
        chk_both("R8 R9 tie after A served", 2'b10, 2'b01);
        req_a = 1'b0; req_b = 1'b0; tick();
        req_a = 1'b1; req_b = 1'b1; tick();
        chk_both("R8 R9 tie after B served", 2'b10, 2'b10);
        req_a = 1'b0; tick();
        chk_both("R6 tie winner releases", 2'b00, 2'b00);
        tick();
        chk_both("R7 tie loser served", 2'b01, 2'b01);
        req_b = 1'b0; tick();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #1;
        do_reset();
        t_idle();
        t_lone_a();
        t_lone_b();
        t_hold_and_queue();
        t_ties();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

endmodule